// File: doc/BRIEF.md
# Breaker Failure Multi-Level Timer

This block watches a circuit breaker once an external breaker-failure initiate signal is raised. It receives a current magnitude as an unsigned 16-bit word, computed upstream. The word is valid when a sample strobe pulses. It also receives a 1 ms tick enable. The block compares the latched current against three static pickup thresholds and runs delay timers. From these it drives two level outputs: a retrip command that repeats the open command to the breaker, and a second-step trip.

The retrip level has its own threshold and its own timer. The high-set and low-set comparators feed a single shared second-step timer. That element is picked up while the current is above either threshold, so it drops out only when the current is at or below both. Every timer counts only while the initiate input is high. Removing the initiate clears all timers and outputs. A delay setting is in milliseconds, and a setting of 0 makes the element operate at once.

Top module: `bkr_fail_timer`

## Requirements
- R1: A synchronous active-low reset clears both timers, the latched current and both outputs to 0.
- R2: The current word is latched only on a clock where `sample_stb` is 1; a changed `cur_mag` without the strobe has no effect on the outputs.
- R3: Pickup is strictly greater-than: a latched current equal to a threshold does not pick up that level.
- R4: With initiate high and the latched current above `thr_retrip`, the retrip timer counts ticks; `retrip_o` goes to 1 on the clock after the timer reaches `dly_retrip` ticks.
- R5: A delay setting of 0 asserts the output on the clock after the first clock where the pickup condition holds, without any tick.
- R6: The second-step element is picked up when the latched current is above `thr_high` or above `thr_low`; `step2_trip_o` goes to 1 on the clock after its timer reaches `dly_step2` ticks.
- R7: The second-step element stays picked up while the current remains above either threshold. When the current is at or below both thresholds, `step2_trip_o` and its timer clear on the next clock.
- R8: When `bf_init` is 0, both timers and both outputs clear on the next clock and the timers do not advance, so a fresh initiate needs the full delay again.
- R9: Any clock where an element's pickup condition is false restarts that element's timer from zero.
- R10: `retrip_o` clears on the clock after the latched current falls to or below `thr_retrip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-clock pulse every millisecond, advances timers |
| sample_stb | input | 1 | Latches `cur_mag` on this clock |
| cur_mag | input | 16 | Current magnitude, unsigned |
| bf_init | input | 1 | External breaker-failure initiate |
| thr_retrip | input | 16 | Retrip pickup threshold |
| thr_high | input | 16 | High-set pickup threshold |
| thr_low | input | 16 | Low-set pickup threshold |
| dly_retrip | input | 16 | Retrip delay in ms ticks |
| dly_step2 | input | 16 | Second-step delay in ms ticks |
| retrip_o | output | 1 | Retrip command level |
| step2_trip_o | output | 1 | Second-step trip level |

## Verification
A strobed current appears in the latch one clock after the strobe. Its pickup therefore affects a timer on the following clock, and an output can change one clock after that. This gives two clocks from strobe to output for a zero delay or a drop-out. A removed initiate clears the outputs one clock after it is sampled low. An output rises one clock after the edge at which the counting tick brings its timer to the delay. Inputs change on falling edges and outputs are compared on falling edges. The comparison is against a bench reference model that advances on the same rising edges. The directed checks wait exactly these counts of clocks before sampling.

// File: rtl/bft_pkg.sv
package bft_pkg;
    parameter int CUR_W = 16;
    parameter int DLY_W = 16;
    parameter int STEP_THR_N = 2;

    typedef logic [CUR_W-1:0] cur_t;
    typedef logic [DLY_W-1:0] dly_t;

    typedef struct packed {
        dly_t cnt;
        logic op;
    } tmr_st_t;
endpackage

// File: rtl/bft_pickup.sv
module bft_pickup
    import bft_pkg::*;
#(
    parameter int N_THR = 1
) (
    input  cur_t                        cur_i,
    input  logic [N_THR-1:0][CUR_W-1:0] thr_i,
    output logic                        pick_o
);
    logic [N_THR-1:0] hit;

    for (genvar gi = 0; gi < N_THR; gi++) begin : g_cmp
        assign hit[gi] = cur_i > thr_i[gi];
    end

    assign pick_o = |hit;
endmodule

// File: rtl/bft_timer.sv
module bft_timer
    import bft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic pick_i,
    input  logic tick_i,
    input  dly_t dly_i,
    output logic op_o
);
    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!arm_i || !pick_i) begin
            st_d.cnt = '0;
            st_d.op  = 1'b0;
        end else begin
            st_d.op = (st_q.cnt >= dly_i);
            if (tick_i && (st_q.cnt < dly_i)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_o = st_q.op;

    p_clear_no_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (!op_o && st_q.cnt == '0));

    p_drop_on_nopick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_i |=> (!op_o && st_q.cnt == '0));

    p_rise_after_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_o) |-> ($past(st_q.cnt) >= $past(dly_i)));

    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && pick_i && !tick_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/bkr_fail_timer.sv
module bkr_fail_timer
    import bft_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_ms,
    input  logic        sample_stb,
    input  logic [15:0] cur_mag,
    input  logic        bf_init,
    input  logic [15:0] thr_retrip,
    input  logic [15:0] thr_high,
    input  logic [15:0] thr_low,
    input  logic [15:0] dly_retrip,
    input  logic [15:0] dly_step2,
    output logic        retrip_o,
    output logic        step2_trip_o
);
    cur_t cur_d, cur_q;
    logic pick_rt, pick_s2;
    logic [STEP_THR_N-1:0][CUR_W-1:0] step_thr;

    always_comb begin
        cur_d = cur_q;
        if (sample_stb) begin
            cur_d = cur_mag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(cur_q));

    assign step_thr[0] = thr_high;
    assign step_thr[1] = thr_low;

    bft_pickup #(.N_THR(1)) i_pick_rt (
        .cur_i  (cur_q),
        .thr_i  (thr_retrip),
        .pick_o (pick_rt)
    );

    bft_pickup #(.N_THR(STEP_THR_N)) i_pick_s2 (
        .cur_i  (cur_q),
        .thr_i  (step_thr),
        .pick_o (pick_s2)
    );

    bft_timer i_tmr_rt (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (bf_init),
        .pick_i (pick_rt),
        .tick_i (tick_ms),
        .dly_i  (dly_retrip),
        .op_o   (retrip_o)
    );

    bft_timer i_tmr_s2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (bf_init),
        .pick_i (pick_s2),
        .tick_i (tick_ms),
        .dly_i  (dly_step2),
        .op_o   (step2_trip_o)
    );

    p_s2_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q <= thr_high && cur_q <= thr_low) |=> !step2_trip_o);

    p_rt_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q <= thr_retrip) |=> !retrip_o);
endmodule

// File: tb/test_bkr_fail_timer.sv
module test_bkr_fail_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] cur_mag = '0;
    logic        bf_init = 1'b0;
    logic [15:0] thr_retrip = 16'd1000;
    logic [15:0] thr_high = 16'd3000;
    logic [15:0] thr_low = 16'd2000;
    logic [15:0] dly_retrip = 16'd3;
    logic [15:0] dly_step2 = 16'd5;
    logic        retrip_o, step2_trip_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bkr_fail_timer i_bkr_fail_timer (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .sample_stb(sample_stb),
        .cur_mag(cur_mag), .bf_init(bf_init), .thr_retrip(thr_retrip),
        .thr_high(thr_high), .thr_low(thr_low), .dly_retrip(dly_retrip),
        .dly_step2(dly_step2), .retrip_o(retrip_o), .step2_trip_o(step2_trip_o)
    );

    // reference model, built from the requirements
    logic [15:0] m_cur;
    int          m_cnt_rt, m_cnt_s2;
    logic        m_rt, m_s2;

    function automatic int next_cnt(bit cond, bit tk, int cnt, int dly);
        if (!cond) return 0;
        if (tk && cnt < dly) return cnt + 1;
        return cnt;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur <= '0; m_cnt_rt <= 0; m_cnt_s2 <= 0; m_rt <= 0; m_s2 <= 0;
        end else begin
            automatic bit c_rt = bf_init && (m_cur > thr_retrip);
            automatic bit c_s2 = bf_init && ((m_cur > thr_high) || (m_cur > thr_low));
            if (sample_stb) m_cur <= cur_mag;
            m_cnt_rt <= next_cnt(c_rt, tick_ms, m_cnt_rt, int'(dly_retrip));
            m_cnt_s2 <= next_cnt(c_s2, tick_ms, m_cnt_s2, int'(dly_step2));
            m_rt <= c_rt && (m_cnt_rt >= int'(dly_retrip));
            m_s2 <= c_s2 && (m_cnt_s2 >= int'(dly_step2));
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 retrip vs model", retrip_o, m_rt);
            chk("R6 step2 vs model", step2_trip_o, m_s2);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    task automatic sample(input logic [15:0] v);
        @(negedge clk); sample_stb = 1'b1; cur_mag = v;
        @(negedge clk); sample_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R1 retrip in reset", retrip_o, 1'b0);
        chk("R1 step2 in reset", step2_trip_o, 1'b0);
        @(negedge clk); rst_n = 1'b1; bf_init = 1'b1;
        cyc(1);
        chk("R1 retrip after reset", retrip_o, 1'b0);

        // R3: equal to thresholds does not pick up
        sample(16'd1000); tick(8);
        chk("R3 retrip at equal threshold", retrip_o, 1'b0);
        sample(16'd2000); tick(8);
        chk("R3 step2 at equal low threshold", step2_trip_o, 1'b0);

        // R2: unstrobed current ignored
        sample(16'd500);
        @(negedge clk); cur_mag = 16'd2500;
        tick(10);
        chk("R2 retrip no strobe", retrip_o, 1'b0);
        chk("R2 step2 no strobe", step2_trip_o, 1'b0);

        // R4 / R6: current above low only
        sample(16'd2500); tick(2);
        chk("R4 retrip before delay", retrip_o, 1'b0);
        tick(1); cyc(1);
        chk("R4 retrip at delay", retrip_o, 1'b1);
        tick(1);
        chk("R6 step2 before delay", step2_trip_o, 1'b0);
        tick(1); cyc(1);
        chk("R6 step2 above low only", step2_trip_o, 1'b1);

        // R7: stays while above either, drops below both
        sample(16'd3500); cyc(1);
        chk("R7 step2 above both", step2_trip_o, 1'b1);
        sample(16'd2100); cyc(1);
        chk("R7 step2 back above low", step2_trip_o, 1'b1);
        sample(16'd1500); cyc(1);
        chk("R7 step2 below both", step2_trip_o, 1'b0);
        chk("R10 retrip still above its level", retrip_o, 1'b1);
        sample(16'd800); cyc(1);
        chk("R10 retrip dropped", retrip_o, 1'b0);

        // R8: initiate removal
        sample(16'd3500); tick(6); cyc(1);
        chk("R8 retrip armed", retrip_o, 1'b1);
        @(negedge clk); bf_init = 1'b0;
        cyc(1);
        chk("R8 retrip cleared", retrip_o, 1'b0);
        chk("R8 step2 cleared", step2_trip_o, 1'b0);
        tick(6);
        @(negedge clk); bf_init = 1'b1;
        tick(1); cyc(1);
        chk("R8 timer restarted", retrip_o, 1'b0);

        // R9: interruption restarts timer
        sample(16'd500); cyc(1);
        sample(16'd3500); tick(2);
        sample(16'd500); cyc(1);
        sample(16'd3500); tick(2); cyc(1);
        chk("R9 retrip after restart", retrip_o, 1'b0);
        tick(1); cyc(1);
        chk("R9 retrip after full delay", retrip_o, 1'b1);

        // R5: zero delay
        sample(16'd500); cyc(1);
        @(negedge clk); dly_retrip = 16'd0;
        sample(16'd1500);
        chk("R5 retrip not yet", retrip_o, 1'b0);
        cyc(1);
        chk("R5 retrip zero delay", retrip_o, 1'b1);

        // random phase, checked against the model each cycle
        @(negedge clk); dly_retrip = 16'd3;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            sample_stb = ($urandom % 4) == 0;
            case ($urandom % 8)
                0: cur_mag = 16'd500;   1: cur_mag = 16'd1000;
                2: cur_mag = 16'd1500;  3: cur_mag = 16'd2000;
                4: cur_mag = 16'd2500;  5: cur_mag = 16'd3000;
                6: cur_mag = 16'd3500;  default: cur_mag = 16'($urandom);
            endcase
            tick_ms = ($urandom % 3) == 0;
            bf_init = ($urandom % 40) != 0;
            if (i == 2000) dly_step2 = 16'd0;
        end
        @(negedge clk);
        finish_run();
    end
endmodule